// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Expander

This block turns a one-bit serial stream into a parallel word and holds that word on its outputs. Bits go into a chain of shift stages one at a time. A separate latch step then copies every stage into a holding register in a single step. The parallel outputs come from the holding register, so they stay unchanged while the next word is being shifted in. The last shift stage is brought out as a cascade bit. Several instances can be chained by feeding one cascade bit into the next instance's serial input and sharing the shift and latch strobes.

Both steps are clock enables on one system clock: `shift_stb` for shifting and `latch_stb` for latching. The shift chain has its own asynchronous active-low clear. The `USE_OE` parameter sets the role of the `ctrl_n` pin. With `USE_OE` = 0, `ctrl_n` is an asynchronous active-low clear for the holding register. With `USE_OE` = 1, `ctrl_n` is an active-low output enable. The enable is brought out as a per-bit enable vector, `par_oe`, and a pad ring can use that vector to put the pins in high impedance.

Top module: `latched_sipo_expander`

## Requirements
- R1: Each clock edge with `shift_stb` high and `shift_clr_n` high puts `ser_in` into stage bit 0 and moves every other stage up one bit position. The first bit sent therefore reaches bit WIDTH-1 after WIDTH such edges. With WIDTH = 8, sending 1,0,1,1 into a cleared chain gives the word 8'h0B.
- R2: An edge with `latch_stb` high copies the whole shift word into the holding register in one step. `par_q` shows the copied word from that edge onward.
- R3: While `latch_stb` stays low, `par_q` does not change, however many shift edges occur.
- R4: `shift_clr_n` low sets every shift stage to 0 at once, without waiting for a clock edge. `cas_out` reads 0 while the clear is held.
- R5: With `USE_OE` = 0, `ctrl_n` low sets the holding register, and so `par_q`, to 0 without waiting for a clock edge. In this variant `par_oe` is all ones at all times.
- R6: With `USE_OE` = 1, `ctrl_n` high makes every bit of `par_oe` 0 and `ctrl_n` low makes every bit 1. Changing `ctrl_n` leaves the held word, and so `par_q`, unchanged.
- R7: `cas_out` is stage bit WIDTH-1. Two instances chained through it, sharing both strobes, pass the first word shifted into the first instance on to the second instance after 2×WIDTH shifts.
- R8: A clear takes priority over its clock enable. A shift strobe given while `shift_clr_n` is low leaves every stage at 0.
- R9: When a shift and a latch happen on the same edge, the latch copies the shift word as it was before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift stages |
| ser_in | input | 1 | Serial data bit |
| shift_stb | input | 1 | Shift enable for the current clock edge |
| latch_stb | input | 1 | Enable for copying the shift word into the holding register |
| ctrl_n | input | 1 | Holding-register clear (USE_OE=0) or output enable (USE_OE=1), active low |
| par_q | output | WIDTH | Held parallel word |
| par_oe | output | WIDTH | Per-bit output enable for the pad drivers |
| cas_out | output | 1 | Last shift stage, for chaining |

## Verification
A shift stage that holds a wrong value is hidden from `par_q` until the next latch edge. It only becomes visible on `cas_out` once the bad bit has moved up to the last stage, which can take up to WIDTH shifts. A holding register that changes when it should not shows up on `par_q` right after the offending edge. A wrong clear or enable state shows up on `par_q` or `par_oe` without any clock edge. The bench therefore latches after short shift sequences to expose the stages early, and it compares a chained second instance to check the bits that leave through the cascade.

// File: rtl/sipo_shifter.sv
module sipo_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             shift_stb,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages,
  output logic             shift_evt
);

  // Next shift word: the new bit enters bit 0 and every other bit moves up one place.
  function automatic logic [WIDTH-1:0] step(input logic [WIDTH-1:0] cur, input logic b);
    return {cur[WIDTH-2:0], b};
  endfunction

  assign shift_evt = shift_stb & clr_n;

  // The clear acts without a clock edge and overrides the shift strobe (R4, R8).
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)         stages <= '0;
    else if (shift_stb) stages <= step(stages, ser_in);
  end

  p_shift_move_r1: assert property (@(posedge clk) disable iff (!clr_n)
    shift_evt |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});

  p_clear_zero_r4: assert property (@(posedge clk)
    !clr_n |-> stages == '0);

  p_clear_prio_r8: assert property (@(posedge clk)
    (!clr_n && shift_stb) |-> stages == '0);

endmodule

// File: rtl/sipo_hold.sv
module sipo_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             latch_stb,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] held,
  output logic             latch_evt
);

  assign latch_evt = latch_stb & clr_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)         held <= '0;
    else if (latch_stb) held <= word_in;
  end

  // R2 and R9: the word copied is the shift word sampled at the latch edge,
  // before any shift made on that same edge.
  p_latch_copy_r2: assert property (@(posedge clk) disable iff (!clr_n)
    latch_evt |=> held == $past(word_in));

  p_hold_steady_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !latch_stb |=> $stable(held));

  p_hold_clear_r5: assert property (@(posedge clk)
    !clr_n |-> held == '0);

endmodule

// File: rtl/latched_sipo_expander.sv
module latched_sipo_expander #(
  parameter int WIDTH  = 8,
  parameter bit USE_OE = 1'b0
) (
  input  logic             clk,
  input  logic             shift_clr_n,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             latch_stb,
  input  logic             ctrl_n,
  output logic [WIDTH-1:0] par_q,
  output logic [WIDTH-1:0] par_oe,
  output logic             cas_out
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_word;
  logic [WIDTH-1:0] held_word;
  logic             shift_evt;
  logic             latch_evt;
  logic             hold_clr_n;

  sipo_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .clr_n    (shift_clr_n),
    .shift_stb(shift_stb),
    .ser_in   (ser_in),
    .stages   (shift_word),
    .shift_evt(shift_evt)
  );

  sipo_hold #(.WIDTH(WIDTH)) u_hold (
    .clk      (clk),
    .clr_n    (hold_clr_n),
    .latch_stb(latch_stb),
    .word_in  (shift_word),
    .held     (held_word),
    .latch_evt(latch_evt)
  );

  generate
    if (USE_OE) begin : g_enable
      assign hold_clr_n = 1'b1;
      assign par_oe     = {WIDTH{~ctrl_n}};

      p_float_r6: assert property (@(posedge clk)
        ctrl_n |-> par_oe == '0);
      p_drive_r6: assert property (@(posedge clk)
        !ctrl_n |-> par_oe == '1);
      p_keep_r6: assert property (@(posedge clk)
        (!latch_evt && $changed(ctrl_n)) |-> $stable(par_q));
    end else begin : g_clear
      assign hold_clr_n = ctrl_n;
      assign par_oe     = '1;
    end
  endgenerate

  assign par_q   = held_word;
  assign cas_out = shift_word[LAST];

  p_cascade_r7: assert property (@(posedge clk) disable iff (!shift_clr_n)
    shift_evt |=> cas_out == $past(shift_word[LAST-1]));

endmodule

// File: tb/sim_latched_sipo_expander.sv
module sim_latched_sipo_expander;

  logic       clk = 1'b0;
  logic       shift_clr_n, sin, shift_stb, latch_stb, hclr_n, oe_n;
  logic [7:0] q0, oe0, q1, oe1;
  logic       cas0, cas1;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  latched_sipo_expander #(.WIDTH(8), .USE_OE(1'b0)) u0 (
    .clk(clk), .shift_clr_n(shift_clr_n), .ser_in(sin), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .ctrl_n(hclr_n), .par_q(q0), .par_oe(oe0), .cas_out(cas0));

  latched_sipo_expander #(.WIDTH(8), .USE_OE(1'b1)) u1 (
    .clk(clk), .shift_clr_n(shift_clr_n), .ser_in(cas0), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .ctrl_n(oe_n), .par_q(q1), .par_oe(oe1), .cas_out(cas1));

  // Pairs {first byte sent, second byte sent}.
  localparam logic [15:0] VEC [0:5] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h8001, 16'h6E91, 16'h5AA5};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); sin = b; shift_stb = 1'b1;
    @(negedge clk); shift_stb = 1'b0;
  endtask

  task automatic shift_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic do_latch();
    @(negedge clk); latch_stb = 1'b1;
    @(negedge clk); latch_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    shift_clr_n = 1'b0; hclr_n = 1'b0; oe_n = 1'b1;
    sin = 1'b0; shift_stb = 1'b0; latch_stb = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R5 reset par_q", q0, 8'h00);
    chk("R5 par_oe ones", oe0, 8'hFF);
    chk("R4 reset cas_out", {7'd0, cas0}, 8'h00);
    chk("R6 floating oe", oe1, 8'h00);
    shift_clr_n = 1'b1; hclr_n = 1'b1; oe_n = 1'b0;

    // R1: 1,0,1,1 into cleared stages
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
    do_latch();
    chk("R1 four-bit word", q0, 8'h0B);
    for (int i = 0; i < 4; i++) shift_bit(1'b0);
    chk("R7 first bit at cascade", {7'd0, cas0}, 8'h01);
    chk("R3 held during shifting", q0, 8'h0B);
    do_latch();
    chk("R1 eight shifts", q0, 8'hB0);
    prev = 8'hB0;

    // Table walk: chained pair, hold stability, latch copy
    for (int k = 0; k < 6; k++) begin
      shift_byte(VEC[k][15:8]);
      shift_byte(VEC[k][7:0]);
      chk("R3 unchanged before latch", q0, prev);
      do_latch();
      chk("R2 latched word", q0, VEC[k][7:0]);
      chk("R7 chained word", q1, VEC[k][15:8]);
      prev = VEC[k][7:0];
    end

    // R6: enable variant keeps contents while outputs float
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    chk("R6 disabled oe", oe1, 8'h00);
    chk("R6 contents kept", q1, 8'h5A);
    chk("R5 clear variant oe", oe0, 8'hFF);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R6 enabled oe", oe1, 8'hFF);
    chk("R6 contents after enable", q1, 8'h5A);

    // R5: asynchronous holding clear between edges
    #2 hclr_n = 1'b0;
    #1;
    chk("R5 async clear", q0, 8'h00);
    chk("R5 other instance kept", q1, 8'h5A);
    @(negedge clk); hclr_n = 1'b1;

    // R9: shift and latch on the same edge
    shift_byte(8'h5A);
    @(negedge clk); sin = 1'b1; shift_stb = 1'b1; latch_stb = 1'b1;
    @(negedge clk); shift_stb = 1'b0; latch_stb = 1'b0;
    chk("R9 pre-shift word", q0, 8'h5A);
    do_latch();
    chk("R9 post-shift word", q0, 8'hB5);

    // R4 and R8: clear overrides shifting, acts without an edge
    #2 shift_clr_n = 1'b0;
    #1;
    chk("R4 async shifter clear", {7'd0, cas0}, 8'h00);
    @(negedge clk); sin = 1'b1; shift_stb = 1'b1;
    repeat (2) @(negedge clk);
    shift_stb = 1'b0; shift_clr_n = 1'b1;
    do_latch();
    chk("R8 clear wins over shift", q0, 8'h00);
    chk("R8 chained clear", q1, 8'h00);
    shift_bit(1'b1);
    do_latch();
    chk("R1 shift after release", q0, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule